// File: doc/BRIEF.md
# Configurable SPI Transfer Engine

This block moves one serial character at a time between a CPU register bus and a four-wire SPI link. The same shift logic serves two roles. As a master, it derives the serial clock from the system clock through an 8-bit divider. As a slave, it follows an external serial clock for as long as its select input is at the active level. Software chooses the clock polarity, the clock phase, a character length of 8 or 16 bits and the active level of the select input. It then starts or preloads a character by writing the data register.

Four sticky event flags record the following conditions:
- a finished character;
- a data write that lands while a character is still moving;
- a receive that overwrites unread data;
- a master that sees its select input driven active.

When the interrupt enable bit in the configuration register is set, any raised flag drives a single interrupt output.

Top module: `spi_engine`

## Requirements
- R1: After reset the configuration, divide and control registers read 0, all flags are clear, `sclk_o` is low and `irq_o` is low.
- R2: The register map is address 0 configuration, 1 divide, 2 control/status, 3 data. Configuration bit 0 is polarity, bit 1 is phase, bit 2 is 16-bit length, bit 6 is active-high select and bit 7 is interrupt enable. Bits 5:3 always read 0.
- R3: In master mode each half period of `sclk_o` lasts N+1 system cycles, where N is the divide value (0 to 255). A character of L bits takes 2·L·(N+1) cycles from the data write until the done flag (status bit 4) is set.
- R4: With no transfer running, `sclk_o` rests at the polarity bit. The first edge of a character is the active edge. Phase 0 samples input on active edges and phase 1 samples on inactive edges, and output bits change on the opposite edges.
- R5: Data moves most significant bit first. An 8-bit character uses data bits 7:0 and reads back zero-extended, and a 16-bit character uses all 16 bits.
- R6: With control bit 0 (enable) set and control bit 1 (master) clear, the engine shifts on the external `sclk_i` only while `ss_i` is at the level that configuration bit 6 selects. In that mode `sclk_o` stays at its idle level whatever the divide value.
- R7: A data write while a character is in flight sets the collision flag (status bit 5) and does not disturb the bits being shifted.
- R8: Finishing a character while the previous one is unread (status bit 3) sets the overrun flag (status bit 6). Reading the data register clears status bit 3.
- R9: An enabled master whose select input goes active sets the mode-fault flag (status bit 7), clears the master bit (status bit 1) and stops any transfer, returning `sclk_o` to idle.
- R10: `irq_o` is high exactly when the interrupt enable bit is set and at least one flag is set.
- R11: Writing control bits 7:4 with ones clears the matching flags, and zeros leave them unchanged. Status bit 2 reads 1 while a character is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (data-register read side effect) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock driven as master |
| sclk_i | input | 1 | Serial clock received as slave |
| mosi_o | output | 1 | Serial data out as master |
| mosi_i | input | 1 | Serial data in as slave |
| miso_o | output | 1 | Serial data out as slave |
| miso_i | input | 1 | Serial data in as master |
| ss_i | input | 1 | Slave-select input |

## Verification
The bench builds the engine with its default parameters: a 16-bit data path, an 8-bit short character, an 8-bit divider and two synchronizer stages. At these values it sweeps every combination of polarity, phase and length against divide values 0, 1, 2 and 5, so the back-to-back tick case and multi-cycle half periods are both covered. On each edge it drives the serial input with the correct bit only in the window that belongs to the sampling edge and with the inverted bit elsewhere. A wrong sampling edge therefore changes the received word. Slave runs use both select polarities and both lengths.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef struct packed {
    logic       irq_en;
    logic       ss_hi;
    logic [2:0] rsvd;
    logic       len16;
    logic       pha;
    logic       pol;
  } cfg_t;

  typedef struct packed {
    logic modf;
    logic ovr;
    logic coll;
    logic done;
  } flags_t;

  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_DIV = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
  localparam logic [1:0] ADDR_DAT = 2'd3;
  localparam logic [7:0] CFG_WMASK = 8'hC7;
endpackage

// File: rtl/spi_eng_sync.sv
module spi_eng_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_eng_clkgen.sv
module spi_eng_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             lead_o,
  output logic             trail_o,
  output logic             lvl_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             lvl_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lead_o  = tick_o & ~lvl_q;
  assign trail_o = tick_o & lvl_q;
  assign lvl_o   = lvl_q;

  // R3: a nonzero divide never yields ticks on consecutive cycles
  a_r3_half_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || !$stable(div_i)));
  // R4: the clock level is back at rest one cycle after run drops
  a_r4_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !lvl_o);
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              len16_i,
  input  logic              pha_i,
  input  logic              abort_i,
  input  logic              lead_i,
  input  logic              trail_i,
  input  logic              in_bit_i,
  output logic              out_bit_o,
  output logic              done_o,
  output logic              active_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int CNT_W = $clog2(2 * DATA_W);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(2 * DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(2 * SHORT_W - 1);

  logic [DATA_W-1:0] tx_q, rx_q, rx_nxt, len_mask;
  logic [CNT_W-1:0]  ecnt_q, last_idx;
  logic              any_edge, sample_e, drive_e;

  assign last_idx = len16_i ? LAST_LONG : LAST_SHORT;
  assign any_edge = lead_i | trail_i;
  assign sample_e = pha_i ? trail_i : lead_i;
  assign drive_e  = pha_i ? lead_i : trail_i;
  assign done_o   = any_edge && !abort_i && (ecnt_q == last_idx);
  assign active_o = (ecnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecnt_q <= '0;
    end else if (abort_i) begin
      ecnt_q <= '0;
    end else if (any_edge) begin
      ecnt_q <= (ecnt_q == last_idx) ? '0 : ecnt_q + 1'b1;
    end
  end

  // the first edge of a character never shifts; its bit is already on the line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
    end else if (load_i) begin
      tx_q <= len16_i ? load_data_i
                      : {load_data_i[SHORT_W-1:0], {(DATA_W-SHORT_W){1'b0}}};
    end else if (drive_e && !abort_i && ecnt_q != '0) begin
      tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (sample_e) rx_q <= rx_nxt;
  end

  assign rx_nxt    = sample_e ? {rx_q[DATA_W-2:0], in_bit_i} : rx_q;
  assign len_mask  = {{(DATA_W-SHORT_W){len16_i}}, {SHORT_W{1'b1}}};
  assign rx_o      = rx_nxt & len_mask;
  assign out_bit_o = tx_q[DATA_W-1];

  // R5: a finished character leaves the edge counter at its start
  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !active_o);
  // R4: leading and trailing edges are exclusive
  a_r4_one_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_i && trail_i));
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SHORT_W     = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              sclk_o,
  input  logic              sclk_i,
  output logic              mosi_o,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              miso_i,
  input  logic              ss_i
);
  localparam int PAD_W = DATA_W - 8;
  localparam int DPAD  = DATA_W - DIV_W;

  cfg_t             cfg_q;
  flags_t           flags_q, flags_set, flags_clr;
  logic [DIV_W-1:0] div_q;
  logic [DATA_W-1:0] rx_q, sh_rx;
  logic en_q, mst_q, run_q, rx_full_q;
  logic wr_cfg, wr_div, wr_ctl, wr_dat, rd_dat;
  logic ss_s, sclk_s, mosi_s, sclk_d;
  logic ss_act, slave_on, s_rise, s_fall, s_lead, s_trail;
  logic m_tick, m_lead, m_trail, m_lvl, clk_run;
  logic lead, trail, in_bit, sh_done, sh_active, sh_out;
  logic busy, modf_evt, coll_evt, load, start, abort;

  assign wr_cfg = bus_wr_i && bus_addr_i == ADDR_CFG;
  assign wr_div = bus_wr_i && bus_addr_i == ADDR_DIV;
  assign wr_ctl = bus_wr_i && bus_addr_i == ADDR_CTL;
  assign wr_dat = bus_wr_i && bus_addr_i == ADDR_DAT;
  assign rd_dat = bus_rd_i && bus_addr_i == ADDR_DAT;

  spi_eng_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_i, sclk_i, mosi_i}),
    .q_o   ({ss_s, sclk_s, mosi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end

  assign ss_act   = cfg_q.ss_hi ? ss_s : ~ss_s;
  assign slave_on = en_q && !mst_q && ss_act;
  assign s_rise   = sclk_s & ~sclk_d;
  assign s_fall   = ~sclk_s & sclk_d;
  assign s_lead   = slave_on && (cfg_q.pol ? s_fall : s_rise);
  assign s_trail  = slave_on && (cfg_q.pol ? s_rise : s_fall);

  assign clk_run = run_q && mst_q;

  spi_eng_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (clk_run),
    .div_i  (div_q),
    .tick_o (m_tick),
    .lead_o (m_lead),
    .trail_o(m_trail),
    .lvl_o  (m_lvl)
  );

  assign lead   = mst_q ? m_lead  : s_lead;
  assign trail  = mst_q ? m_trail : s_trail;
  assign in_bit = mst_q ? miso_i  : mosi_s;

  assign modf_evt = en_q && mst_q && ss_act;
  assign busy     = run_q || (!mst_q && sh_active);
  assign coll_evt = wr_dat && busy;
  assign load     = wr_dat && !busy;
  assign start    = load && en_q && mst_q && !modf_evt;
  assign abort    = modf_evt || (!mst_q && !slave_on);

  spi_eng_shifter #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) i_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_data_i(bus_wdata_i),
    .len16_i    (cfg_q.len16),
    .pha_i      (cfg_q.pha),
    .abort_i    (abort),
    .lead_i     (lead),
    .trail_i    (trail),
    .in_bit_i   (in_bit),
    .out_bit_o  (sh_out),
    .done_o     (sh_done),
    .active_o   (sh_active),
    .rx_o       (sh_rx)
  );

  always_comb begin
    flags_set.modf = modf_evt;
    flags_set.ovr  = sh_done && rx_full_q && !rd_dat;
    flags_set.coll = coll_evt;
    flags_set.done = sh_done;
    flags_clr      = wr_ctl ? flags_t'(bus_wdata_i[7:4]) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      div_q     <= '0;
      en_q      <= 1'b0;
      mst_q     <= 1'b0;
      run_q     <= 1'b0;
      flags_q   <= '0;
      rx_q      <= '0;
      rx_full_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_t'(bus_wdata_i[7:0] & CFG_WMASK);
      if (wr_div) div_q <= bus_wdata_i[DIV_W-1:0];
      if (wr_ctl) en_q <= bus_wdata_i[0];
      if (modf_evt)    mst_q <= 1'b0;
      else if (wr_ctl) mst_q <= bus_wdata_i[1];
      if (modf_evt || sh_done || !mst_q || !en_q) run_q <= 1'b0;
      else if (start)                             run_q <= 1'b1;
      flags_q <= (flags_q & ~flags_clr) | flags_set;
      if (sh_done) begin
        rx_q      <= sh_rx;
        rx_full_q <= 1'b1;
      end else if (rd_dat) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr_i)
      ADDR_CFG: bus_rdata_o = {{PAD_W{1'b0}}, cfg_q};
      ADDR_DIV: bus_rdata_o = {{DPAD{1'b0}}, div_q};
      ADDR_CTL: bus_rdata_o = {{PAD_W{1'b0}}, flags_q, rx_full_q, busy, mst_q, en_q};
      default:  bus_rdata_o = rx_q;
    endcase
  end

  assign irq_o  = cfg_q.irq_en && (flags_q != '0);
  assign sclk_o = cfg_q.pol ^ m_lvl;
  assign mosi_o = sh_out;
  assign miso_o = sh_out;

  // R6: no master clock activity outside master mode
  a_r6_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mst_q |-> !m_tick);
  // R7: data write during a character raises collision
  a_r7_coll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && busy) |=> flags_q.coll);
  // R8: completion over unread data raises overrun
  a_r8_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_done && rx_full_q && !rd_dat) |=> flags_q.ovr);
  // R9: mode fault drops master role and stops the transfer
  a_r9_modf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modf_evt |=> (!mst_q && !run_q && flags_q.modf));
  // R4: idle master rests at the polarity level
  a_r4_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_q && !run_q && $past(!run_q)) |-> (sclk_o == cfg_q.pol));
  // R10: interrupt only rises when enabled
  a_r10_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> cfg_q.irq_en);
endmodule

// File: tb/test_spi_engine.sv
module test_spi_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        irq, sclk_o, mosi_o, miso_o;
  logic        sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_i = 1'b1;
  int          checks = 0, fails = 0, cycles = 0;
  logic [15:0] st;

  spi_engine i_spi_engine (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
    .bus_rd_i(bus_rd), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .sclk_o(sclk_o), .sclk_i(sclk_i), .mosi_o(mosi_o),
    .mosi_i(mosi_i), .miso_o(miso_o), .miso_i(miso_i), .ss_i(ss_i)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic logic pbit(input logic [15:0] p, input int len, input int i);
    return p[len-1-i];
  endfunction

  task automatic mx(input logic pol, input logic pha, input logic l16, input int dv,
                    input logic ie, input logic [15:0] tx, input logic [15:0] pat,
                    input int coll_at);
    int len, cyc, last, ec, bi, hp_err;
    logic prev;
    logic [15:0] got, mask, d;
    len = l16 ? 16 : 8;
    mask = l16 ? 16'hFFFF : 16'h00FF;
    wr(2'd0, {8'h0, ie, 1'b0, 3'b0, l16, pha, pol});
    wr(2'd1, 16'(dv));
    wr(2'd2, 16'h00F3);
    chk("R4 idle level", sclk_o, pol);
    chk("R10 no flag no irq", irq, 1'b0);
    miso_i = pha ? ~pbit(pat, len, 0) : pbit(pat, len, 0);
    wr(2'd3, tx);
    bus_addr = 2'd2;
    cyc = 0; last = 0; ec = 0; bi = 0; hp_err = 0; got = '0; prev = sclk_o;
    while (cyc < 5000) begin
      @(negedge clk); cyc++;
      if (coll_at > 0 && cyc == coll_at) begin
        bus_addr = 2'd3; bus_wdata = ~tx; bus_wr = 1'b1;
      end else if (coll_at > 0 && cyc == coll_at + 1) begin
        bus_wr = 1'b0; bus_addr = 2'd2;
      end
      #1;
      if (sclk_o !== prev) begin
        if (cyc - last != dv + 1) hp_err++;
        if (ec[0] == pha) begin
          got = {got[14:0], mosi_o};
          if (bi < len) miso_i = ~pbit(pat, len, bi);
          bi++;
        end else if (bi < len) begin
          miso_i = pbit(pat, len, bi);
        end
        ec++; last = cyc; prev = sclk_o;
      end
      if (bus_addr == 2'd2 && bus_rdata[4]) break;
    end
    chk("R3 transfer length", cyc, 2 * len * (dv + 1));
    chk("R3 half periods", hp_err, 0);
    chk("R3 edge count", ec, 2 * len);
    chk("R5 mosi msb first", got, tx & mask);
    chk("R4 back to idle", sclk_o, pol);
    chk("R10 irq gating", irq, ie);
    if (coll_at > 0) begin
      peek(2'd2, st);
      chk("R7 collision flag", st[5], 1'b1);
    end
    rd(2'd3, d);
    chk("R5 received word", d, pat & mask);
    peek(2'd2, st);
    chk("R8 read clears full", st[3], 1'b0);
  endtask

  task automatic sx(input logic pol, input logic pha, input logic l16, input logic sh,
                    input logic [15:0] tx, input logic [15:0] pat);
    int len, kk, idle_err;
    logic [15:0] got, mask, d;
    len = l16 ? 16 : 8;
    mask = l16 ? 16'hFFFF : 16'h00FF;
    ss_i = ~sh; sclk_i = pol;
    wr(2'd0, {8'h0, 1'b0, sh, 3'b0, l16, pha, pol});
    wr(2'd1, 16'h0007);
    wr(2'd2, 16'h00F1);
    wr(2'd3, tx);
    repeat (3) @(negedge clk);
    ss_i = sh; mosi_i = pbit(pat, len, 0);
    idle_err = 0; got = '0;
    repeat (6) begin @(negedge clk); if (sclk_o !== pol) idle_err++; end
    for (int e = 0; e < 2 * len; e++) begin
      repeat (8) begin @(negedge clk); if (sclk_o !== pol) idle_err++; end
      if (e % 2 == int'(pha)) begin
        got = {got[14:0], miso_o};
        sclk_i = ~sclk_i;
      end else begin
        sclk_i = ~sclk_i;
        kk = pha ? e / 2 : e / 2 + 1;
        if (kk < len) mosi_i = pbit(pat, len, kk);
      end
    end
    repeat (8) @(negedge clk);
    peek(2'd2, st);
    chk("R6 slave done", st[4], 1'b1);
    rd(2'd3, d);
    chk("R6 slave received", d, pat & mask);
    chk("R5 slave miso msb first", got, tx & mask);
    chk("R6 sclk_o idle in slave", idle_err, 0);
    ss_i = ~sh;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    chk("R1 sclk low in reset", sclk_o, 1'b0);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), d);
      chk("R1 register reset", d, 16'h0);
    end
    chk("R1 irq low", irq, 1'b0);

    wr(2'd0, 16'h00FF);
    peek(2'd0, d);
    chk("R2 reserved read zero", d, 16'h00C7);
    wr(2'd0, 16'h0000);

    for (int i = 0; i < 32; i++) begin
      int dv;
      dv = (i >> 3) == 3 ? 5 : (i >> 3);
      mx(i[0], i[1], i[2], dv, i[0] ^ i[3], 16'hA5C3 ^ 16'(i * 16'h1357),
         16'h3C96 + 16'(i * 777), 0);
    end

    // R7: write during transfer
    mx(1'b0, 1'b1, 1'b0, 2, 1'b0, 16'h00B4, 16'h0059, 3);

    // R8 / R11: overrun then write-one-to-clear
    wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd2, 16'h00F3);
    miso_i = 1'b1;
    wr(2'd3, 16'h005A);
    repeat (30) @(negedge clk);
    peek(2'd2, st);
    chk("R8 no overrun first", st[6], 1'b0);
    wr(2'd3, 16'h00A5);
    repeat (30) @(negedge clk);
    peek(2'd2, st);
    chk("R8 overrun flag", st[6], 1'b1);
    chk("R8 full flag", st[3], 1'b1);
    wr(2'd2, 16'h0003);
    peek(2'd2, st);
    chk("R11 zero keeps done", st[4], 1'b1);
    wr(2'd2, 16'h0013);
    peek(2'd2, st);
    chk("R11 one clears done", st[4], 1'b0);
    chk("R11 others kept", st[6], 1'b1);
    rd(2'd3, d);
    chk("R8 latest word", d, 16'h00FF);

    // R9: mode fault, active-low select
    wr(2'd0, 16'h0080); wr(2'd2, 16'h00F3);
    ss_i = 1'b0;
    repeat (4) @(negedge clk);
    peek(2'd2, st);
    chk("R9 modf flag", st[7], 1'b1);
    chk("R9 master cleared", st[1], 1'b0);
    chk("R10 irq on modf", irq, 1'b1);
    ss_i = 1'b1;
    wr(2'd2, 16'h00F0);
    #1 chk("R10 irq after clear", irq, 1'b0);

    // R9: abort mid-transfer
    wr(2'd0, 16'h0000); wr(2'd1, 16'h0005); wr(2'd2, 16'h00F3);
    wr(2'd3, 16'h0034);
    repeat (20) @(negedge clk);
    ss_i = 1'b0;
    repeat (4) @(negedge clk);
    ss_i = 1'b1;
    repeat (2) @(negedge clk);
    peek(2'd2, st);
    chk("R9 abort stops busy", st[2], 1'b0);
    chk("R9 abort idle clock", sclk_o, 1'b0);

    // R9: active-high select
    ss_i = 1'b0;
    wr(2'd0, 16'h0040); wr(2'd2, 16'h00F3);
    repeat (4) @(negedge clk);
    peek(2'd2, st);
    chk("R9 inactive high-sel", st[7], 1'b0);
    ss_i = 1'b1;
    repeat (4) @(negedge clk);
    peek(2'd2, st);
    chk("R9 active high-sel", st[7], 1'b1);
    wr(2'd2, 16'h00F0);

    // R6: slave mode sweep
    for (int i = 0; i < 8; i++)
      sx(i[0], i[1], i[2], i[0] ^ i[2], 16'hC35A ^ 16'(i * 16'h0F21),
         16'h6B1D + 16'(i * 311));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule